// File: doc/BRIEF.md
# Multiplexed GPIO Pin Bank

This block controls a bank of 32 general-purpose pins through a small word-addressed register port. Each pin has one bit in each of six control bitmaps: output level, direction, pull disable, two function-select bits and a sleep bit. For every pin the block drives an output value, an output enable, a pull enable and a pull direction toward the pad. A pin carries either its own GPIO signals or the output/enable pair of one of three peripheral functions (A, B, C). Pin levels are resynchronised before software reads them.

The output-level and direction bitmaps each have a set alias and a clear alias, so a single write can change one pin without a read-modify-write. The pull direction is not a separate bitmap: when the pull is on, the pin's output-level bit picks up or down. A sleep-force input, raised by the platform on entry to a low-power state, overrides the function selection of every pin whose sleep bit is 0. That pin falls back to GPIO and reports wakeup detection as enabled. Dropping the input restores every pin's selected function without any register write.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, the output-level, direction, pull-disable and both select bitmaps read 0, and the sleep bitmap reads all ones. The pins then show output enable 0, output 0, pull enable all ones, pull direction 0 and wakeup enable 0.
- R2: Word 1 reads and writes the output-level bitmap directly. Writing word 2 sets every bit that is 1 in the write data, and writing word 3 clears every such bit. Zero bits leave the bitmap unchanged. Reads of words 2 and 3 return the output-level bitmap.
- R3: Word 4 reads and writes the direction bitmap, where 1 means output. Word 5 sets the bits written as 1 and word 6 clears them. Reads of words 5 and 6 return the direction bitmap.
- R4: Each pin's function is decoded from its select bits: select-A at word 8 and select-B at word 9. With neither bit set the pin is GPIO, driving enable from its direction bit and value from its output-level bit. A alone selects function A, B alone selects function B, and both bits select function C. A pin in a peripheral function drives both enable and value from that function's ports.
- R5: The pull-disable bitmap is at word 7. Pull enable is the inverse of that bitmap, and pull direction equals the output-level bit (1 means up).
- R6: Word 0 returns the pin input levels through a two-stage synchroniser. A level applied before a clock edge is seen by a read after the second rising edge, and not after the first.
- R7: While sleep-force is high, a pin whose sleep bit (word 10) is 0 is driven as GPIO whatever its select bits are, and its wakeup-enable output is 1.
- R8: While sleep-force is high, a pin whose sleep bit is 1 keeps its selected function and has wakeup enable 0. When sleep-force is low, every pin follows its select bits, all wakeup enables are 0, and no register write is needed.
- R9: Words 11 to 15 read as 0, and writes to them change no bitmap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe; data is stored at the rising edge |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 32 | Pad input levels |
| sleep_force | input | 1 | Forces pins with sleep bit 0 into GPIO |
| fa_out | input | 32 | Function A output values |
| fa_oe | input | 32 | Function A output enables |
| fb_out | input | 32 | Function B output values |
| fb_oe | input | 32 | Function B output enables |
| fc_out | input | 32 | Function C output values |
| fc_oe | input | 32 | Function C output enables |
| pin_out | output | 32 | Value driven to each pad |
| pin_oe | output | 32 | Output enable to each pad |
| pull_en | output | 32 | Pull resistor enable per pad |
| pull_up | output | 32 | Pull direction per pad, 1 is up |
| wake_en | output | 32 | Wakeup detection enable per pin |

## Verification
The pad outputs are combinational from the stored bitmaps. A wrong bitmap bit therefore shows on pin_oe, pin_out, pull_en or pull_up in the same cycle the register settles, and on reg_rdata when that word is read. A wrong set or clear alias shows up as neighbouring pins changing when they should hold. A wrong function decode shows as the wrong peripheral's pattern on a pin. A wrong synchroniser depth shows as the input word changing one edge early or late. A lost force override shows as a peripheral value on a pin that should have fallen back to GPIO.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int N_PINS = 32;
    localparam int ADDR_W = 4;
    localparam int SYNC_STAGES = 2;

    // word addresses of the register port
    localparam logic [ADDR_W-1:0] A_PIN_IN   = 4'd0;
    localparam logic [ADDR_W-1:0] A_DOUT     = 4'd1;
    localparam logic [ADDR_W-1:0] A_DOUT_SET = 4'd2;
    localparam logic [ADDR_W-1:0] A_DOUT_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIR      = 4'd4;
    localparam logic [ADDR_W-1:0] A_DIR_SET  = 4'd5;
    localparam logic [ADDR_W-1:0] A_DIR_CLR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_PDIS     = 4'd7;
    localparam logic [ADDR_W-1:0] A_SEL_A    = 4'd8;
    localparam logic [ADDR_W-1:0] A_SEL_B    = 4'd9;
    localparam logic [ADDR_W-1:0] A_SLEEP    = 4'd10;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_A    = 2'd1,
        FN_B    = 2'd2,
        FN_C    = 2'd3
    } pin_fn_e;

    typedef struct packed {
        logic [N_PINS-1:0] dout;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] pdis;
        logic [N_PINS-1:0] sel_a;
        logic [N_PINS-1:0] sel_b;
        logic [N_PINS-1:0] sleep;
    } bank_cfg_t;

    function automatic pin_fn_e fn_decode(input logic a, input logic b);
        return pin_fn_e'({b, a});
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] d,
    output logic [N_PINS-1:0] q
);
    logic [N_PINS-1:0] stage [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[SYNC_STAGES-1];

    // R6: the read word lags the pad by exactly two edges
    p_sync_two_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] sync_in,
    output bank_cfg_t         cfg,
    output logic [N_PINS-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            cfg.sleep <= '1;
        end else if (wr) begin
            case (addr)
                A_DOUT:     cfg.dout  <= wdata;
                A_DOUT_SET: cfg.dout  <= cfg.dout | wdata;
                A_DOUT_CLR: cfg.dout  <= cfg.dout & ~wdata;
                A_DIR:      cfg.dir   <= wdata;
                A_DIR_SET:  cfg.dir   <= cfg.dir | wdata;
                A_DIR_CLR:  cfg.dir   <= cfg.dir & ~wdata;
                A_PDIS:     cfg.pdis  <= wdata;
                A_SEL_A:    cfg.sel_a <= wdata;
                A_SEL_B:    cfg.sel_b <= wdata;
                A_SLEEP:    cfg.sleep <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_PIN_IN:                      rdata = sync_in;
            A_DOUT, A_DOUT_SET, A_DOUT_CLR: rdata = cfg.dout;
            A_DIR, A_DIR_SET, A_DIR_CLR:    rdata = cfg.dir;
            A_PDIS:                        rdata = cfg.pdis;
            A_SEL_A:                       rdata = cfg.sel_a;
            A_SEL_B:                       rdata = cfg.sel_b;
            A_SLEEP:                       rdata = cfg.sleep;
            default:                       rdata = '0;
        endcase
    end

    // R2: set alias raises written ones and keeps the other bits
    p_dout_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_DOUT_SET) |=>
        ((cfg.dout & $past(wdata)) == $past(wdata)) &&
        ((cfg.dout & ~$past(wdata)) == ($past(cfg.dout) & ~$past(wdata))));

    // R2: clear alias drops written ones and keeps the other bits
    p_dout_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_DOUT_CLR) |=>
        ((cfg.dout & $past(wdata)) == '0) &&
        ((cfg.dout & ~$past(wdata)) == ($past(cfg.dout) & ~$past(wdata))));

    // R3: direction aliases never touch the output-level bitmap
    p_dir_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == A_DIR_SET || addr == A_DIR_CLR)) |=> $stable(cfg.dout));

    // R9: unmapped words store nothing
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && addr > A_SLEEP) |=> $stable(cfg));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_mux_pkg::*;
(
    input  bank_cfg_t         cfg,
    input  logic              force_in,
    input  logic [N_PINS-1:0] fa_out,
    input  logic [N_PINS-1:0] fa_oe,
    input  logic [N_PINS-1:0] fb_out,
    input  logic [N_PINS-1:0] fb_oe,
    input  logic [N_PINS-1:0] fc_out,
    input  logic [N_PINS-1:0] fc_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pull_en,
    output logic [N_PINS-1:0] pull_up,
    output logic [N_PINS-1:0] wake_en
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic    forced;
        pin_fn_e fn;

        assign forced = force_in & ~cfg.sleep[i];
        assign fn     = forced ? FN_GPIO : fn_decode(cfg.sel_a[i], cfg.sel_b[i]);

        always_comb begin
            case (fn)
                FN_A:    begin pin_oe[i] = fa_oe[i];   pin_out[i] = fa_out[i];   end
                FN_B:    begin pin_oe[i] = fb_oe[i];   pin_out[i] = fb_out[i];   end
                FN_C:    begin pin_oe[i] = fc_oe[i];   pin_out[i] = fc_out[i];   end
                default: begin pin_oe[i] = cfg.dir[i]; pin_out[i] = cfg.dout[i]; end
            endcase
        end

        assign pull_en[i] = ~cfg.pdis[i];
        assign pull_up[i] = cfg.dout[i];
        assign wake_en[i] = forced;
    end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_PINS-1:0] reg_wdata,
    output logic [N_PINS-1:0] reg_rdata,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              sleep_force,
    input  logic [N_PINS-1:0] fa_out,
    input  logic [N_PINS-1:0] fa_oe,
    input  logic [N_PINS-1:0] fb_out,
    input  logic [N_PINS-1:0] fb_oe,
    input  logic [N_PINS-1:0] fc_out,
    input  logic [N_PINS-1:0] fc_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pull_en,
    output logic [N_PINS-1:0] pull_up,
    output logic [N_PINS-1:0] wake_en
);
    logic [N_PINS-1:0] sync_in;
    bank_cfg_t         cfg;

    gpio_in_sync u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_in)
    );

    gpio_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sync_in (sync_in),
        .cfg     (cfg),
        .rdata   (reg_rdata)
    );

    gpio_pin_mux u_mux (
        .cfg      (cfg),
        .force_in (sleep_force),
        .fa_out   (fa_out),
        .fa_oe    (fa_oe),
        .fb_out   (fb_out),
        .fb_oe    (fb_oe),
        .fc_out   (fc_out),
        .fc_oe    (fc_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pull_en  (pull_en),
        .pull_up  (pull_up),
        .wake_en  (wake_en)
    );

    // R7: a forced pin shows its GPIO enable and value
    p_force_gpio_r7: assert property (@(posedge clk) disable iff (rst)
        sleep_force |-> ((((pin_oe ^ cfg.dir) | (pin_out ^ cfg.dout)) & ~cfg.sleep) == '0));

    // R8: no wakeup without the force input
    p_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
        !sleep_force |-> (wake_en == '0));

    // R4: unselected pins carry their own GPIO value
    p_gpio_out_r4: assert property (@(posedge clk) disable iff (rst)
        (((pin_out ^ cfg.dout) & ~(cfg.sel_a | cfg.sel_b)) == '0));

endmodule

// File: tb/gpio_mux_bank_bench.sv
module gpio_mux_bank_bench;
    import gpio_mux_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [N_PINS-1:0] reg_wdata = '0;
    logic [N_PINS-1:0] reg_rdata;
    logic [N_PINS-1:0] pin_in = '0;
    logic              sleep_force = 1'b0;
    logic [N_PINS-1:0] fa_out = 32'hA5A5A5A5, fa_oe = 32'h0000FFFF;
    logic [N_PINS-1:0] fb_out = 32'h12345678, fb_oe = 32'hFF00FF00;
    logic [N_PINS-1:0] fc_out = 32'hCAFEBABE, fc_oe = 32'h0F0F0F0F;
    logic [N_PINS-1:0] pin_out, pin_oe, pull_en, pull_up, wake_en;

    localparam logic [31:0] DIR_PAT  = 32'h3C3C3C3C;
    localparam logic [31:0] DOUT_PAT = 32'h96969696;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_mux_bank u_gpio_mux_bank (.*);

    typedef struct packed {
        logic [31:0] sa;
        logic [31:0] sb;
        logic [31:0] slp;
        logic        frc;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0},
        '{32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1'b0},
        '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
        '{32'h0F0F0F0F, 32'h00FF00FF, 32'hFFFFFFFF, 1'b1},
        '{32'h0F0F0F0F, 32'h00FF00FF, 32'h0000FFFF, 1'b1},
        '{32'h0F0F0F0F, 32'h00FF00FF, 32'h0000FFFF, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_DOUT, v);  chk("R1 dout", v, 32'h0);
        rd(A_DIR, v);   chk("R1 dir", v, 32'h0);
        rd(A_PDIS, v);  chk("R1 pdis", v, 32'h0);
        rd(A_SEL_A, v); chk("R1 sel_a", v, 32'h0);
        rd(A_SEL_B, v); chk("R1 sel_b", v, 32'h0);
        rd(A_SLEEP, v); chk("R1 sleep", v, 32'hFFFFFFFF);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 pull_en", pull_en, 32'hFFFFFFFF);
        chk("R1 pull_up", pull_up, 32'h0);
        chk("R1 wake_en", wake_en, 32'h0);

        // R2 output-level aliases
        wr(A_DOUT_SET, 32'h000000F0); rd(A_DOUT, v);     chk("R2 set", v, 32'h000000F0);
        wr(A_DOUT_SET, 32'h0000000F); rd(A_DOUT_SET, v); chk("R2 set keep", v, 32'h000000FF);
        wr(A_DOUT_CLR, 32'h00000030); rd(A_DOUT_CLR, v); chk("R2 clr", v, 32'h000000CF);
        wr(A_DOUT, DOUT_PAT);         rd(A_DOUT, v);     chk("R2 plain", v, DOUT_PAT);

        // R3 direction aliases
        wr(A_DIR_SET, DIR_PAT);      rd(A_DIR, v);     chk("R3 set", v, DIR_PAT);
        wr(A_DIR_CLR, 32'h00000004); rd(A_DIR_SET, v); chk("R3 clr", v, 32'h3C3C3C38);
        chk("R3 pin_oe", pin_oe, 32'h3C3C3C38);
        wr(A_DIR, DIR_PAT);          rd(A_DIR_CLR, v); chk("R3 plain", v, DIR_PAT);

        // R5 pull control
        wr(A_PDIS, 32'h0000FFFF);
        chk("R5 pull_en", pull_en, 32'hFFFF0000);
        chk("R5 pull_up", pull_up, DOUT_PAT);
        wr(A_DOUT_CLR, 32'h00000002);
        chk("R5 pull_up follows", pull_up, DOUT_PAT & ~32'h2);
        wr(A_DOUT, DOUT_PAT);

        // R4 / R7 / R8 table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] eoe, eout, ewk;
            wr(A_SEL_A, VECS[k].sa);
            wr(A_SEL_B, VECS[k].sb);
            wr(A_SLEEP, VECS[k].slp);
            sleep_force = VECS[k].frc;
            #1;
            for (int i = 0; i < N_PINS; i++) begin
                logic fr;
                fr = VECS[k].frc && !VECS[k].slp[i];
                if (fr || (!VECS[k].sa[i] && !VECS[k].sb[i])) begin
                    eoe[i] = DIR_PAT[i]; eout[i] = DOUT_PAT[i];
                end else if (VECS[k].sa[i] && !VECS[k].sb[i]) begin
                    eoe[i] = fa_oe[i]; eout[i] = fa_out[i];
                end else if (!VECS[k].sa[i]) begin
                    eoe[i] = fb_oe[i]; eout[i] = fb_out[i];
                end else begin
                    eoe[i] = fc_oe[i]; eout[i] = fc_out[i];
                end
                ewk[i] = fr;
            end
            chk(VECS[k].frc ? "R7 R4 oe" : "R8 R4 oe", pin_oe, eoe);
            chk(VECS[k].frc ? "R7 R4 out" : "R8 R4 out", pin_out, eout);
            chk(VECS[k].frc ? "R7 wake" : "R8 wake", wake_en, ewk);
        end
        sleep_force = 1'b0;

        // R6 two-stage input path
        @(negedge clk);
        pin_in = 32'h5A5A0FF0;
        @(negedge clk);
        rd(A_PIN_IN, v); chk("R6 one edge", v, 32'h0);
        @(negedge clk);
        rd(A_PIN_IN, v); chk("R6 two edges", v, 32'h5A5A0FF0);

        // R9 unmapped words
        rd(4'd12, v); chk("R9 read", v, 32'h0);
        wr(4'd11, 32'hFFFFFFFF);
        wr(4'd15, 32'hFFFFFFFF);
        rd(A_DOUT, v);  chk("R9 dout kept", v, DOUT_PAT);
        rd(A_SLEEP, v); chk("R9 sleep kept", v, 32'h0000FFFF);
        rd(A_PDIS, v);  chk("R9 pdis kept", v, 32'h0000FFFF);

        finish_run();
    end

endmodule